// File: doc/BRIEF.md
# Endpoint packet buffer with commit and rollback

This block sits between a small full-speed USB function core and the user logic of one data endpoint pair. It stores bytes in two circular buffers and works on whole packets rather than single bytes. On the receive side (host to device), bytes from the core are written ahead of a committed pointer. They become visible to the user only when the transfer closes cleanly. A transfer that carries a payload CRC error, times out, or overruns the free space is erased by moving the speculative write pointer back to the committed one.

On the transmit side (device to host), the user fills the buffer and the core drains it during an IN transfer. Storage is released only when the transfer closes without a timeout. After a timeout (no ACK from the host), the speculative read pointer is moved back, so the next IN transfer offers the same bytes again. Neither the core nor the user logic has to keep its own copy of a packet.

One small state machine per direction finds the transfer boundaries from the core's busy flag and endpoint-select bus. Its states are IDLE, XFER and FAULT. The transitions are: T_START (IDLE to XFER), T_GOOD (XFER to IDLE, commit), T_BAD_END (XFER to IDLE, rollback, error seen in the closing cycle), T_FAULT (XFER to FAULT, error seen mid-transfer) and T_ABORT (FAULT to IDLE, rollback).

Top module: `ep_pkt_buf`

## Requirements
- R1: After reset, rx_empty is 1, rx_level and tx_level are 0, tx_full is 0 and rx_dropped is 0.
- R2: A transfer begins in the cycle where core_busy is 1, was 0 in the previous cycle, and core_ep equals the endpoint number of that direction (OUT_EP for receive, IN_EP for transmit). core_wr strobes outside a receive transfer, or during a transfer on another endpoint, store nothing.
- R3: A receive transfer ends in the first cycle where core_busy is 0, or where core_ep differs from OUT_EP. In that closing cycle the packet is committed if no error was seen. rx_level counts committed, unread bytes only: it stays unchanged while a packet is being written and rises by the packet length on the clock edge that ends the closing cycle.
- R4: A core_crc_err or core_tmo pulse at any point during a receive transfer, including its closing cycle, discards every byte of that packet: rx_level is unchanged afterwards, and the next clean packet is stored and read back intact.
- R5: If a received packet has more bytes than the free space (DEPTH minus rx_level), none of its bytes are kept. rx_dropped is then 1 for exactly one cycle, starting on the same edge at which the packet would have been committed.
- R6: A receive transfer closed by core_ep moving to another endpoint while core_busy stays 1 commits exactly as one closed by core_busy falling.
- R7: rx_rdata shows the next committed byte in the cycle after rx_rd is sampled high. Consecutive rx_rd cycles return consecutive bytes in arrival order. rx_rd while rx_empty is 1 leaves rx_rdata and rx_level unchanged.
- R8: tx_wr stores tx_wdata while tx_level is below DEPTH. tx_full is 1 exactly when tx_level equals DEPTH, and writes while full are ignored. tx_level counts bytes written and not yet acknowledged.
- R9: During a transmit transfer, core_rdata shows the next byte in the cycle after core_rd is sampled high, in write order. A transfer closing without core_tmo releases the bytes it read, so tx_level falls by that count on the closing edge.
- R10: A core_tmo pulse during a transmit transfer keeps tx_level unchanged and rewinds the read position, so the next transmit transfer presents again the oldest unacknowledged byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_busy | input | 1 | Core is inside a transaction |
| core_ep | input | EPW | Endpoint addressed by the current transaction |
| core_crc_err | input | 1 | Payload CRC error pulse for the received packet |
| core_tmo | input | 1 | Timeout pulse (no ACK during IN, no data during OUT) |
| core_wr | input | 1 | Core writes a received byte |
| core_wdata | input | 8 | Received byte |
| core_rd | input | 1 | Core requests the next byte to transmit |
| core_rdata | output | 8 | Byte to transmit, valid one cycle after core_rd |
| rx_rd | input | 1 | User reads a received byte |
| rx_rdata | output | 8 | Received byte, valid one cycle after rx_rd |
| rx_empty | output | 1 | No committed unread byte |
| rx_level | output | LW | Committed unread bytes |
| rx_dropped | output | 1 | One-cycle pulse: a packet did not fit and was dropped |
| tx_wr | input | 1 | User writes a byte to transmit |
| tx_wdata | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit storage holds DEPTH unacknowledged bytes |
| tx_level | output | LW | Bytes written and not yet acknowledged |

## Verification
The bench uses an 8-byte buffer and sweeps every receive packet length from 1 to the full depth. It runs clean, CRC-failed and timed-out packets, and closes transfers both by busy falling and by an endpoint change. A design that commits early would show a rising level mid-packet. A design that ignores errors in the closing cycle would keep a bad packet. One that fails to rewind would leave stale bytes ahead of the next good packet. Overflow is tested one byte past the free space and exactly at it, which exposes a wrongly placed full comparison or a partly stored packet. On the transmit side, a timed-out transfer is replayed and its bytes are compared one by one. This catches a read pointer that rewinds to the wrong place or frees storage before acknowledgement.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_FAULT = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/ep_xfer_ctrl.sv
module ep_xfer_ctrl
    import ep_buf_pkg::*;
#(
    parameter int unsigned EPW    = 4,
    parameter int unsigned EP_NUM = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic [EPW-1:0] ep_sel,
    input  logic           err,
    output logic           active,
    output logic           commit,
    output logic           rollback
);

    localparam logic [EPW-1:0] EP_CODE = EPW'(EP_NUM);

    xfer_state_e state_q, state_d;
    logic        busy_q;
    logic        ep_hit, start, fin;

    assign ep_hit = (ep_sel == EP_CODE);
    assign start  = busy && !busy_q && ep_hit;
    assign fin    = !busy || !ep_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            busy_q  <= busy;
        end
    end

    // next state: T_START, T_GOOD, T_BAD_END, T_FAULT, T_ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_XFER;
            ST_XFER: begin
                if (fin)      state_d = ST_IDLE;
                else if (err) state_d = ST_FAULT;
            end
            ST_FAULT: if (fin) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active   = 1'b0;
        commit   = 1'b0;
        rollback = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                active   = !fin;
                commit   = fin && !err;
                rollback = fin && err;
            end
            ST_FAULT: rollback = fin;
            default: ;
        endcase
    end

    // R4: a transfer has a single outcome
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, rollback}));

    // R2: no data phase or outcome outside a transfer
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(active || commit || rollback));

    // R4: after an error mid-transfer the packet can no longer be committed
    a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (active && err) |=> !commit);

endmodule

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         wr_commit,
    input  logic                         wr_rollback,
    input  logic                         rd_en,
    input  logic                         rd_commit,
    input  logic                         rd_rollback,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         wr_room
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_spec, wr_cmt, rd_spec, rd_cmt;
    logic [PW-1:0] wr_spec_d, wr_cmt_d, rd_spec_d, rd_cmt_d;
    logic          wr_acc, rd_acc;

    assign wr_room   = ((wr_spec - rd_cmt) != PW'(DEPTH));
    assign wr_acc    = wr_en && wr_room;
    assign rd_acc    = rd_en && (rd_spec != wr_cmt);

    assign wr_spec_d = wr_rollback ? wr_cmt : wr_spec + PW'(wr_acc);
    assign wr_cmt_d  = wr_commit ? wr_spec_d : wr_cmt;
    assign rd_spec_d = rd_rollback ? rd_cmt : rd_spec + PW'(rd_acc);
    assign rd_cmt_d  = rd_commit ? rd_spec_d : rd_cmt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_spec <= '0;
            wr_cmt  <= '0;
            rd_spec <= '0;
            rd_cmt  <= '0;
            level   <= '0;
            rd_data <= '0;
        end else begin
            wr_spec <= wr_spec_d;
            wr_cmt  <= wr_cmt_d;
            rd_spec <= rd_spec_d;
            rd_cmt  <= rd_cmt_d;
            level   <= wr_cmt_d - rd_cmt_d;
            if (rd_acc) rd_data <= mem[rd_spec[AW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_spec[AW-1:0]] <= wr_data;
    end

    // R8: occupancy never exceeds the storage
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));

    // R4: a write rollback leaves nothing speculative behind
    a_r4_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rollback && !wr_commit) |=> (wr_spec == wr_cmt));

    // R10: a read rollback restarts at the oldest unacknowledged entry
    a_r10_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rollback && !rd_commit) |=> (rd_spec == rd_cmt));

endmodule

// File: rtl/ep_pkt_buf.sv
module ep_pkt_buf #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned EPW    = 4,
    parameter int unsigned OUT_EP = 1,
    parameter int unsigned IN_EP  = 2,
    localparam int unsigned LW    = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           core_busy,
    input  logic [EPW-1:0] core_ep,
    input  logic           core_crc_err,
    input  logic           core_tmo,
    input  logic           core_wr,
    input  logic [7:0]     core_wdata,
    input  logic           core_rd,
    output logic [7:0]     core_rdata,
    input  logic           rx_rd,
    output logic [7:0]     rx_rdata,
    output logic           rx_empty,
    output logic [LW-1:0]  rx_level,
    output logic           rx_dropped,
    input  logic           tx_wr,
    input  logic [7:0]     tx_wdata,
    output logic           tx_full,
    output logic [LW-1:0]  tx_level
);

    logic rx_active, rx_commit, rx_rollback, rx_room, rx_ovf, rx_err, ovf_seen;
    logic tx_active, tx_commit, tx_rollback, tx_room;

    assign rx_ovf = core_wr && rx_active && !rx_room;
    assign rx_err = core_crc_err || core_tmo || rx_ovf;

    ep_xfer_ctrl #(.EPW(EPW), .EP_NUM(OUT_EP)) u_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .busy(core_busy), .ep_sel(core_ep),
        .err(rx_err), .active(rx_active), .commit(rx_commit),
        .rollback(rx_rollback)
    );

    ep_pkt_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(core_wr && rx_active), .wr_data(core_wdata),
        .wr_commit(rx_commit), .wr_rollback(rx_rollback),
        .rd_en(rx_rd), .rd_commit(1'b1), .rd_rollback(1'b0),
        .rd_data(rx_rdata), .level(rx_level), .wr_room(rx_room)
    );

    ep_xfer_ctrl #(.EPW(EPW), .EP_NUM(IN_EP)) u_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .busy(core_busy), .ep_sel(core_ep),
        .err(core_tmo), .active(tx_active), .commit(tx_commit),
        .rollback(tx_rollback)
    );

    ep_pkt_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr), .wr_data(tx_wdata),
        .wr_commit(1'b1), .wr_rollback(1'b0),
        .rd_en(core_rd && tx_active), .rd_commit(tx_commit),
        .rd_rollback(tx_rollback),
        .rd_data(core_rdata), .level(tx_level), .wr_room(tx_room)
    );

    assign rx_empty = (rx_level == '0);
    assign tx_full  = !tx_room;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_seen   <= 1'b0;
            rx_dropped <= 1'b0;
        end else begin
            rx_dropped <= rx_rollback && ovf_seen;
            if (rx_commit || rx_rollback) ovf_seen <= 1'b0;
            else if (rx_ovf)              ovf_seen <= 1'b1;
        end
    end

    // R5: the drop indication is a single-cycle pulse
    a_r5_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dropped |=> !rx_dropped);

    // R7: a read of an empty receive buffer leaves the data port alone
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty) |=> $stable(rx_rdata));

endmodule

// File: tb/ep_pkt_buf_tb.sv
module ep_pkt_buf_tb;

    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_busy = 1'b0;
    logic [3:0] core_ep = 4'd0;
    logic core_crc_err = 1'b0, core_tmo = 1'b0;
    logic core_wr = 1'b0, core_rd = 1'b0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_rdata;
    logic rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic rx_empty, rx_dropped;
    logic [LW-1:0] rx_level, tx_level;
    logic tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic tx_full;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit got_drop;

    ep_pkt_buf #(.DEPTH(DEPTH), .EPW(4), .OUT_EP(1), .IN_EP(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_busy(core_busy), .core_ep(core_ep),
        .core_crc_err(core_crc_err), .core_tmo(core_tmo),
        .core_wr(core_wr), .core_wdata(core_wdata),
        .core_rd(core_rd), .core_rdata(core_rdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .rx_level(rx_level), .rx_dropped(rx_dropped),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .tx_level(tx_level)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // receive packet: len bytes base+i; bad selects crc (1) or timeout (2)
    task automatic rx_pkt(input int len, input int base, input int bad, input bit epchg);
        int lvl0;
        lvl0 = int'(rx_level);
        core_ep = 4'd1;
        core_busy = 1'b1;
        step();
        for (int i = 0; i < len; i++) begin
            core_wr = 1'b1;
            core_wdata = 8'(base + i);
            step();
        end
        core_wr = 1'b0;
        chk(int'(rx_level) == lvl0, "R3 level held mid-packet", int'(rx_level), lvl0);
        if (bad == 1) core_crc_err = 1'b1;
        if (bad == 2) core_tmo = 1'b1;
        if (bad != 0) step();
        core_crc_err = 1'b0;
        core_tmo = 1'b0;
        if (epchg) core_ep = 4'd3;
        else core_busy = 1'b0;
        step();
        got_drop = rx_dropped;
        core_busy = 1'b0;
        core_ep = 4'd0;
        step();
    endtask

    task automatic rx_read(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            rx_rd = 1'b1;
            step();
            chk(int'(rx_rdata) == ((base + i) & 255), req, int'(rx_rdata), (base + i) & 255);
        end
        rx_rd = 1'b0;
    endtask

    // transmit transfer reading n bytes expected from base
    task automatic tx_xfer(input int n, input int base, input bit tmo);
        core_ep = 4'd2;
        core_busy = 1'b1;
        step();
        for (int i = 0; i < n; i++) begin
            core_rd = 1'b1;
            step();
            chk(int'(core_rdata) == base + i, "R9 transmit byte order", int'(core_rdata), base + i);
        end
        core_rd = 1'b0;
        if (tmo) begin
            core_tmo = 1'b1;
            step();
            core_tmo = 1'b0;
        end
        core_busy = 1'b0;
        step();
        core_ep = 4'd0;
    endtask

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1
        chk(rx_empty == 1'b1, "R1 rx_empty", int'(rx_empty), 1);
        chk(rx_level == 0, "R1 rx_level", int'(rx_level), 0);
        chk(tx_level == 0 && !tx_full, "R1 tx_level/full", int'(tx_level), 0);
        chk(rx_dropped == 1'b0, "R1 rx_dropped", int'(rx_dropped), 0);

        // R2: stray writes, then wrong endpoint
        core_wr = 1'b1;
        core_wdata = 8'h55;
        step(); step(); step();
        core_wr = 1'b0;
        chk(rx_level == 0, "R2 write outside transfer", int'(rx_level), 0);
        core_ep = 4'd3;
        core_busy = 1'b1;
        step();
        core_wr = 1'b1;
        step(); step();
        core_wr = 1'b0;
        core_busy = 1'b0;
        step(); step();
        chk(rx_level == 0, "R2 other endpoint ignored", int'(rx_level), 0);

        // R3, R6, R7: clean packets of every length
        for (int len = 1; len <= DEPTH; len++) begin
            rx_pkt(len, len * 16, 0, (len % 2) == 1);
            chk(int'(rx_level) == len, (len % 2) ? "R6 commit on endpoint change" : "R3 commit on busy fall",
                int'(rx_level), len);
            rx_read(len, len * 16, "R7 receive byte order");
            chk(rx_empty == 1'b1, "R7 empty after drain", int'(rx_empty), 1);
        end

        // R4: crc and timeout packets vanish; next clean one intact
        for (int len = 1; len <= DEPTH; len++) begin
            rx_pkt(len, 8'hE0, (len == 3) ? 2 : 1, (len % 2) == 0);
            chk(rx_level == 0, "R4 bad packet discarded", int'(rx_level), 0);
            rx_pkt(2, len * 8, 0, 1'b0);
            chk(rx_level == 2, "R4 recovery level", int'(rx_level), 2);
            rx_read(2, len * 8, "R4 recovery data");
        end

        // R5: overflow by one byte, then exact fit
        rx_pkt(5, 8'h40, 0, 1'b0);
        rx_pkt(4, 8'h90, 0, 1'b0);
        chk(rx_level == 5, "R5 oversized packet dropped", int'(rx_level), 5);
        chk(got_drop == 1'b1, "R5 drop pulse", int'(got_drop), 1);
        chk(rx_dropped == 1'b0, "R5 drop pulse one cycle", int'(rx_dropped), 0);
        rx_pkt(3, 8'h45, 0, 1'b0);
        chk(rx_level == 8 && got_drop == 1'b0, "R5 exact fit kept", int'(rx_level), 8);
        rx_read(8, 8'h40, "R5 data after drop");

        // R7: empty read leaves data
        rx_rd = 1'b1;
        step(); step();
        rx_rd = 1'b0;
        chk(int'(rx_rdata) == 8'h47 && rx_level == 0, "R7 empty read ignored", int'(rx_rdata), 8'h47);

        // R8: fill past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            tx_wr = 1'b1;
            tx_wdata = 8'(8'hA0 + i);
            step();
            chk(int'(tx_level) == ((i + 1 < DEPTH) ? i + 1 : DEPTH), "R8 tx_level",
                int'(tx_level), (i + 1 < DEPTH) ? i + 1 : DEPTH);
        end
        tx_wr = 1'b0;
        chk(tx_full == 1'b1, "R8 tx_full", int'(tx_full), 1);

        // R9, R10
        tx_xfer(3, 8'hA0, 1'b0);
        chk(tx_level == 5 && !tx_full, "R9 acked bytes freed", int'(tx_level), 5);
        tx_xfer(3, 8'hA3, 1'b1);
        chk(tx_level == 5, "R10 timeout keeps bytes", int'(tx_level), 5);
        tx_xfer(5, 8'hA3, 1'b0);
        chk(tx_level == 0, "R10 replay then ack", int'(tx_level), 0);
        tx_wr = 1'b1;
        tx_wdata = 8'hB0;
        step();
        tx_wdata = 8'hB1;
        step();
        tx_wr = 1'b0;
        tx_xfer(2, 8'hB0, 1'b0);
        chk(tx_level == 0, "R9 wrap drained", int'(tx_level), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule